// File: doc/BRIEF.md
# Modulo-M Phase Accumulator Oscillator

This block is a numerically controlled oscillator whose phase register wraps at a programmable modulus M, not at a power of two. Each clock it adds the increment N, or N−M on a wrap step. The wrap strobe therefore fires exactly N times in every M clocks. The rate is exact for any ratio N/M, with no 1/2^k rounding error. The sum can jitter by up to one clock. The alternate step N−M is derived inside the block from the two programmed values.

A mode input picks one of two value ranges for the accumulator. In the straddling range, the values lie in [N−M, N) and the wrap is decided by the sign of the current value. In the negative range, the values lie in [−M, 0). In that range, both sums are formed and the wrap is decided by the sign of the +N sum. Because neither range is [0, 2^k), the sign bit cannot serve as a square wave. A square output is instead derived from the phase measured above the range's lower bound. N, M and the mode are held stable while the block runs. They are changed only while reset is asserted.

Top module: `dds_modm_top`

## Requirements
- R1: With range_sel = 0, a synchronous reset loads the accumulator with N−M and clears wrap_strobe.
- R2: With range_sel = 1, a synchronous reset loads the accumulator with −M and clears wrap_strobe.
- R3: With range_sel = 0 and 0 ≤ N < M, the accumulator stays within [N−M, N) after reset.
- R4: With range_sel = 1 and 0 ≤ N < M, the accumulator stays within [−M, 0) after reset.
- R5: Each clock out of reset, the accumulator takes one of two steps. It advances by N−M when the wrap condition holds; otherwise it advances by N. With range_sel = 0, the wrap condition is that the value is non-negative. With range_sel = 1, the wrap condition is that the value plus N is non-negative.
- R6: wrap_strobe is high for exactly the one cycle that follows each N−M step, so exactly N strobes occur in the first M cycles after reset.
- R7: sq_out is high when twice the phase is at least M. The phase is the accumulator minus the range's lower bound: N−M for range_sel = 0, and −M for range_sel = 1.
- R8: With N = 0, the accumulator holds its reset value and wrap_strobe never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inc_n | input | W | Increment N, unsigned, must be below M |
| mod_m | input | W | Modulus M, unsigned, at least 1 |
| range_sel | input | 1 | 0: range [N−M, N); 1: range [−M, 0) |
| acc_out | output | W+2 | Accumulator value, two's complement |
| wrap_strobe | output | 1 | One-cycle pulse after each N−M step |
| sq_out | output | 1 | Square wave from the phase in the upper half of the modulus |

## Verification
A wrong wrap decision, or a wrong step constant, leaves the accumulator at a value the arithmetic model did not predict. This shows on acc_out at the very next clock. If the error is large enough, the value also falls outside its range. A wrong wrap decision also produces a strobe pattern that differs from the model within one cycle. Over the first M cycles the strobe total then differs from N, so even a slow drift in rate is caught. A wrong reset value or a wrong lower bound shows on the first sample after reset, and on sq_out within half a period.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // extra accumulator bits beyond the operand width: one for sign, one for headroom
    localparam int ACC_GUARD = 2;

    typedef enum logic {
        RANGE_STRADDLE = 1'b0,
        RANGE_NEGATIVE = 1'b1
    } range_e;

    // decision terms that feed the step multiplexer
    typedef struct packed {
        logic sign_acc;
        logic carry_n;
        logic take_alt;
    } wrap_ctl_t;

    function automatic logic pick_alt(range_e mode, logic sign_acc, logic carry_n);
        return (mode == RANGE_NEGATIVE) ? carry_n : ~sign_acc;
    endfunction

endpackage

// File: rtl/dds_step_gen.sv
module dds_step_gen
    import dds_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]             inc_n,
    input  logic [W-1:0]             mod_m,
    input  range_e                   mode,
    output logic signed [W+ACC_GUARD-1:0] add_norm,
    output logic signed [W+ACC_GUARD-1:0] add_alt,
    output logic signed [W+ACC_GUARD-1:0] neg_mod,
    output logic signed [W+ACC_GUARD-1:0] rst_val
);
    localparam int SW = W + ACC_GUARD;

    logic signed [SW-1:0] n_s;
    logic signed [SW-1:0] m_s;

    always_comb begin
        n_s      = $signed({{ACC_GUARD{1'b0}}, inc_n});
        m_s      = $signed({{ACC_GUARD{1'b0}}, mod_m});
        add_norm = n_s;
        add_alt  = n_s - m_s;
        neg_mod  = -m_s;
        rst_val  = (mode == RANGE_NEGATIVE) ? neg_mod : add_alt;
    end

endmodule

// File: rtl/dds_acc_core.sv
module dds_acc_core
    import dds_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  range_e                        mode,
    input  logic signed [W+ACC_GUARD-1:0] add_norm,
    input  logic signed [W+ACC_GUARD-1:0] add_alt,
    input  logic signed [W+ACC_GUARD-1:0] rst_val,
    output logic signed [W+ACC_GUARD-1:0] acc_q,
    output logic                          strobe_q
);
    localparam int SW = W + ACC_GUARD;

    logic signed [SW-1:0] sum_norm;
    logic signed [SW-1:0] sum_alt;
    logic signed [SW-1:0] acc_d;
    wrap_ctl_t            ctl;

    // both candidate sums are formed every cycle; the mux picks one
    always_comb begin
        sum_norm     = acc_q + add_norm;
        sum_alt      = acc_q + add_alt;
        ctl.sign_acc = acc_q[SW-1];
        ctl.carry_n  = ~sum_norm[SW-1];
        ctl.take_alt = pick_alt(mode, ctl.sign_acc, ctl.carry_n);
        acc_d        = ctl.take_alt ? sum_alt : sum_norm;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= rst_val;
            strobe_q <= 1'b0;
        end else begin
            acc_q    <= acc_d;
            strobe_q <= ctl.take_alt;
        end
    end

endmodule

// File: rtl/dds_square_out.sv
module dds_square_out
    import dds_pkg::*;
#(
    parameter int W = 8
) (
    input  range_e                        mode,
    input  logic signed [W+ACC_GUARD-1:0] acc,
    input  logic signed [W+ACC_GUARD-1:0] add_alt,
    input  logic signed [W+ACC_GUARD-1:0] neg_mod,
    input  logic [W-1:0]                  mod_m,
    output logic                          sq
);
    localparam int SW = W + ACC_GUARD;

    logic signed [SW-1:0] lower;
    logic signed [SW-1:0] phase;
    logic        [SW-1:0] twice;
    logic        [SW-1:0] m_wide;

    always_comb begin
        lower  = (mode == RANGE_NEGATIVE) ? neg_mod : add_alt;
        phase  = acc - lower;
        twice  = {phase[SW-2:0], 1'b0};
        m_wide = {{ACC_GUARD{1'b0}}, mod_m};
        sq     = (twice >= m_wide);
    end

endmodule

// File: rtl/dds_modm_top.sv
module dds_modm_top
    import dds_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [W-1:0]        inc_n,
    input  logic [W-1:0]        mod_m,
    input  logic                range_sel,
    output logic signed [W+1:0] acc_out,
    output logic                wrap_strobe,
    output logic                sq_out
);
    localparam int SW = W + ACC_GUARD;

    range_e               mode;
    logic signed [SW-1:0] add_norm;
    logic signed [SW-1:0] add_alt;
    logic signed [SW-1:0] neg_mod;
    logic signed [SW-1:0] rst_val;
    logic signed [SW-1:0] acc_q;

    assign mode = range_e'(range_sel);

    dds_step_gen #(.W(W)) step_i (
        .inc_n    (inc_n),
        .mod_m    (mod_m),
        .mode     (mode),
        .add_norm (add_norm),
        .add_alt  (add_alt),
        .neg_mod  (neg_mod),
        .rst_val  (rst_val)
    );

    dds_acc_core #(.W(W)) core_i (
        .clk      (clk),
        .rst      (rst),
        .mode     (mode),
        .add_norm (add_norm),
        .add_alt  (add_alt),
        .rst_val  (rst_val),
        .acc_q    (acc_q),
        .strobe_q (wrap_strobe)
    );

    dds_square_out #(.W(W)) sq_i (
        .mode    (mode),
        .acc     (acc_q),
        .add_alt (add_alt),
        .neg_mod (neg_mod),
        .mod_m   (mod_m),
        .sq      (sq_out)
    );

    assign acc_out = acc_q;

endmodule

// File: rtl/dds_modm_chk.sv
module dds_modm_chk #(
    parameter int W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [W-1:0]        inc_n,
    input logic [W-1:0]        mod_m,
    input logic                range_sel,
    input logic signed [W+1:0] acc_out,
    input logic                wrap_strobe,
    input logic                sq_out
);
    logic signed [W+1:0] n_s;
    logic signed [W+1:0] m_s;

    assign n_s = $signed({2'b00, inc_n});
    assign m_s = $signed({2'b00, mod_m});

    AST_RANGE_STRADDLE: assert property (@(posedge clk) disable iff (rst)
        !range_sel |-> (acc_out >= n_s - m_s) && (acc_out < n_s)); // R3

    AST_RANGE_NEGATIVE: assert property (@(posedge clk) disable iff (rst)
        range_sel |-> (acc_out >= -m_s) && (acc_out < 0)); // R4

    AST_STEP_MATCHES_STROBE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (wrap_strobe ? (acc_out == $past(acc_out) + n_s - m_s)
                              : (acc_out == $past(acc_out) + n_s))); // R5

    AST_ZERO_INC_SILENT: assert property (@(posedge clk) disable iff (rst)
        (inc_n == '0) |-> !wrap_strobe); // R8

endmodule

bind dds_modm_top dds_modm_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .inc_n       (inc_n),
    .mod_m       (mod_m),
    .range_sel   (range_sel),
    .acc_out     (acc_out),
    .wrap_strobe (wrap_strobe),
    .sq_out      (sq_out)
);

// File: tb/dds_modm_tb_top.sv
module dds_modm_tb_top;
    localparam int W = 8;
    localparam int CLK_PERIOD = 10;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [W-1:0]        inc_n = '0;
    logic [W-1:0]        mod_m = 8'd1;
    logic                range_sel = 1'b0;
    logic signed [W+1:0] acc_out;
    logic                wrap_strobe;
    logic                sq_out;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dds_modm_top #(.W(W)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .inc_n       (inc_n),
        .mod_m       (mod_m),
        .range_sel   (range_sel),
        .acc_out     (acc_out),
        .wrap_strobe (wrap_strobe),
        .sq_out      (sq_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s n=%0d m=%0d mode=%0d act=%0d exp=%0d",
                     req, inc_n, mod_m, range_sel, act, exp);
        end
    endtask

    // phase p in [0,M) is the model; accumulator = p + lower bound
    task automatic run_cfg(input int n, input int m, input bit mode);
        int p = 0;
        int lo;
        int strobes = 0;
        lo = mode ? -m : n - m;
        @(negedge clk);
        inc_n = W'(n); mod_m = W'(m); range_sel = mode; rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        if (mode) check(int'(acc_out) == -m, "R2 reset value", int'(acc_out), -m);
        else      check(int'(acc_out) == n - m, "R1 reset value", int'(acc_out), n - m);
        check(wrap_strobe == 1'b0, mode ? "R2 reset strobe" : "R1 reset strobe",
              int'(wrap_strobe), 0);
        rst = 1'b0;
        for (int i = 0; i < 2 * m + 3; i++) begin
            int  s;
            bit  w;
            @(negedge clk);
            s = p + n;
            w = (s >= m);
            p = w ? s - m : s;
            if (i < m && w) strobes++;
            check(int'(acc_out) == p + lo, "R5 accumulator step", int'(acc_out), p + lo);
            if (mode) check(int'(acc_out) >= -m && int'(acc_out) < 0,
                            "R4 range", int'(acc_out), -m);
            else      check(int'(acc_out) >= n - m && int'(acc_out) < n,
                            "R3 range", int'(acc_out), n - m);
            check(wrap_strobe == w, "R6 strobe timing", int'(wrap_strobe), int'(w));
            check(sq_out == (2 * p >= m), "R7 square output", int'(sq_out), int'(2 * p >= m));
            if (n == 0) check(int'(acc_out) == lo && !wrap_strobe,
                              "R8 zero increment hold", int'(acc_out), lo);
        end
        check(strobes == n, "R6 strobe count per M cycles", strobes, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired act=%0d exp=%0d", total, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int m = 1; m <= 12; m++)
            for (int n = 0; n < m; n++)
                for (int md = 0; md < 2; md++)
                    run_cfg(n, m, md[0]);
        for (int md = 0; md < 2; md++) begin
            run_cfg(1, 255, md[0]);
            run_cfg(254, 255, md[0]);
            run_cfg(100, 201, md[0]);
            run_cfg(17, 250, md[0]);
            run_cfg(0, 255, md[0]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule